// File: doc/BRIEF.md
# LCD Pixel Memory with Frame-Aligned Update and Blink Masking

This block holds the pixel memory that feeds an LCD waveform sequencer, one bit per pixel. It has two banks. The host bank can be written and read over a simple register port at any time. The display bank is the one the sequencer reads. The host fills the host bank, then sets an update request. The whole host bank is copied into the display bank in one cycle, but only on the next start-of-frame pulse. Because of this, a frame that is being shown never mixes old and new pixel data.

Each start of frame raises a flag. Each completed copy raises a second flag. Both flags are write-1-to-clear, and each has its own interrupt enable. A blink mask sits on the display read path. While the external blink phase input is high, it forces a chosen group of pixels off. The mask changes only the data sent to the sequencer and never the stored bits.

Pixel layout: common k uses words 2k (segments 0 to 31) and 2k+1 (segments 32 to 63). With the default 16 words this gives 8 commons, which covers both an 8×40 and a 4×44 arrangement.

Top module: `lcd_pixel_ram`

## Requirements
- R1: After synchronous reset, every word of both banks reads 0, STATUS reads 0, the request bit is 0 and `irq_o` is low.
- R2: A write to host address a (0 ≤ a < 16) is returned by `host_rdata` from the next cycle on. The display bank is unchanged until a copy happens.
- R3: Writing 1 to CTRL bit 0 (address 16) sets the request bit. It reads back as 1 until a `sof_i` pulse. At that clock edge all words are copied to the display bank and the request bit clears. Writing 0 to bit 0 does not clear it.
- R4: A host write made while a request is pending changes only the host bank. The display does not show it until the copy at the next `sof_i`.
- R5: STATUS (address 17) has bit 0 for start of frame, set on every `sof_i`, and bit 1 for update done, set by each copy. Writing 1 to a bit clears it. A set in the same cycle wins over the clear.
- R6: `irq_o` is high exactly when (STATUS bit 0 AND IEN bit 0) OR (STATUS bit 1 AND IEN bit 1), where IEN is address 18.
- R7: `disp_data_o` shows the word at `disp_addr_i` one rising edge after the address is presented.
- R8: CTRL bits 6:4 select the blink group. While `blink_off_i` is high, the group's pixels are forced to 0. The group is defined as follows:
  - Code 1: SEG0 on COM0, which is bit 0 of word 0.
  - Code 2: SEG0 on COM0 to COM1.
  - Code 3: SEG0 on COM0 to COM2.
  - Code 4: SEG0 on COM0 to COM3.
  - Code 5: SEG0 on COM0 to COM7, which is bit 0 of each even word.
  - Codes 6 and 7: every bit of every word.
  - Code 0: no blinking.
- R9: Blink masking never changes stored data. With `blink_off_i` low, or with code 0, `disp_data_o` equals the stored display word.
- R10: A `sof_i` pulse with no pending request leaves the display bank unchanged and does not set STATUS bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from `host_addr`) |
| sof_i | input | 1 | One-cycle start-of-frame pulse from the sequencer |
| blink_off_i | input | 1 | High during the blink-off half-period |
| disp_addr_i | input | 4 | Display word index |
| disp_data_o | output | 32 | Masked display word, one cycle latency |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some internal faults show up only one frame later on the display port. A request bit that clears too early, or a copy that is not gated by the request, looks like this: after the `sof_i` edge, the display returns new data when it should be old, or old data when it should be new. The bench therefore reads the display words on both sides of every start-of-frame pulse.

A wrong blink decode shows up in the very next display read as a bit 0 in the wrong word. A flag fault shows up at once on `host_rdata` and `irq_o`, in the cycle right after the edge that set or cleared it.

// File: rtl/lcdram_pkg.sv
package lcdram_pkg;

    typedef enum logic [2:0] {
        BLK_NONE    = 3'd0,
        BLK_ONE     = 3'd1,
        BLK_TWO     = 3'd2,
        BLK_THREE   = 3'd3,
        BLK_FOUR    = 3'd4,
        BLK_EIGHT   = 3'd5,
        BLK_ALL     = 3'd6,
        BLK_ALL_ALT = 3'd7
    } blink_mode_e;

    typedef struct packed {
        logic done;
        logic sof;
    } evt_flags_t;

    localparam int unsigned WORDS_PER_COM = 2;

    function automatic int unsigned blink_com_count(blink_mode_e m);
        case (m)
            BLK_ONE:   return 1;
            BLK_TWO:   return 2;
            BLK_THREE: return 3;
            BLK_FOUR:  return 4;
            BLK_EIGHT: return 8;
            default:   return 0;
        endcase
    endfunction

    function automatic logic blink_is_all(blink_mode_e m);
        return (m == BLK_ALL) || (m == BLK_ALL_ALT);
    endfunction

endpackage

// File: rtl/lcdram_ctrl.sv
module lcdram_ctrl
    import lcdram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic        stat_we,
    input  logic        ien_we,
    input  logic [7:0]  wbyte,
    input  logic        sof,
    output logic        pending,
    output logic        copy_en,
    output blink_mode_e blink_mode,
    output evt_flags_t  flags,
    output evt_flags_t  ien,
    output logic        irq
);

    assign copy_en = sof && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= 1'b0;
            blink_mode <= BLK_NONE;
            flags      <= '0;
            ien        <= '0;
        end else begin
            if (ctrl_we && wbyte[0])
                pending <= 1'b1;
            else if (copy_en)
                pending <= 1'b0;
            if (ctrl_we)
                blink_mode <= blink_mode_e'(wbyte[6:4]);
            flags.sof  <= sof     || (flags.sof  && !(stat_we && wbyte[0]));
            flags.done <= copy_en || (flags.done && !(stat_we && wbyte[1]));
            if (ien_we)
                ien <= evt_flags_t'(wbyte[1:0]);
        end
    end

    assign irq = (flags.sof && ien.sof) || (flags.done && ien.done);

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        pending && sof && !(ctrl_we && wbyte[0]) |=> !pending && flags.done); // R3
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        pending && !sof |=> pending); // R3
    AST_SOF_FLAG: assert property (@(posedge clk) disable iff (rst)
        sof |=> flags.sof); // R5
    AST_DONE_ONLY_COPY: assert property (@(posedge clk) disable iff (rst)
        !flags.done && !(sof && pending) |=> !flags.done); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq); // R6

endmodule

// File: rtl/lcdram_banks.sv
module lcdram_banks #(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              copy_en,
    input  logic [IDX_W-1:0]  host_raddr,
    output logic [WORD_W-1:0] host_rword,
    input  logic [IDX_W-1:0]  disp_raddr,
    output logic [WORD_W-1:0] disp_rword
);

    logic [NWORDS-1:0][WORD_W-1:0] wbank;
    logic [NWORDS-1:0][WORD_W-1:0] shadow;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                wbank[i]  <= '0;
                shadow[i] <= '0;
            end else begin
                if (we && (waddr == IDX_W'(i)))
                    wbank[i] <= wdata;
                if (copy_en)
                    shadow[i] <= wbank[i];
            end
        end
    end

    assign host_rword = wbank[host_raddr];
    assign disp_rword = shadow[disp_raddr];

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$past(copy_en) |-> $stable(shadow)); // R4
    AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(copy_en) |-> shadow == $past(wbank)); // R3

endmodule

// File: rtl/lcdram_blink.sv
module lcdram_blink
    import lcdram_pkg::*;
#(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic [IDX_W-1:0]  addr,
    input  blink_mode_e       mode,
    input  logic              blink_off,
    output logic [WORD_W-1:0] data_o
);

    logic [WORD_W-1:0] mask;
    int unsigned       com_idx;
    logic              seg0_word;

    always_comb begin
        com_idx   = 32'(addr) / WORDS_PER_COM;
        seg0_word = (32'(addr) % WORDS_PER_COM) == 0;
        mask      = '0;
        if (blink_off) begin
            if (blink_is_all(mode))
                mask = '1;
            else if (seg0_word && (com_idx < blink_com_count(mode)))
                mask[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_o <= '0;
        else
            data_o <= word_in & ~mask;
    end

    AST_BLINK_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$past(blink_off) |-> data_o == $past(word_in)); // R9
    AST_BLINK_ALL: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(blink_off) && $past(mode == BLK_ALL) |-> data_o == '0); // R8

endmodule

// File: rtl/lcd_pixel_ram.sv
module lcd_pixel_ram
    import lcdram_pkg::*;
#(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = $clog2(NWORDS + 3)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_we,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [WORD_W-1:0]         host_wdata,
    output logic [WORD_W-1:0]         host_rdata,
    input  logic                      sof_i,
    input  logic                      blink_off_i,
    input  logic [$clog2(NWORDS)-1:0] disp_addr_i,
    output logic [WORD_W-1:0]         disp_data_o,
    output logic                      irq_o
);

    localparam int unsigned IDX_W    = $clog2(NWORDS);
    localparam int unsigned CTRL_OFS = NWORDS;
    localparam int unsigned STAT_OFS = NWORDS + 1;
    localparam int unsigned IEN_OFS  = NWORDS + 2;

    logic              sel_ram, sel_ctrl, sel_stat, sel_ien;
    logic              pending, copy_en;
    blink_mode_e       blink_mode;
    evt_flags_t        flags, ien;
    logic [WORD_W-1:0] host_rword, disp_rword;

    assign sel_ram  = 32'(host_addr) < NWORDS;
    assign sel_ctrl = 32'(host_addr) == CTRL_OFS;
    assign sel_stat = 32'(host_addr) == STAT_OFS;
    assign sel_ien  = 32'(host_addr) == IEN_OFS;

    lcdram_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (host_we && sel_ctrl),
        .stat_we    (host_we && sel_stat),
        .ien_we     (host_we && sel_ien),
        .wbyte      (host_wdata[7:0]),
        .sof        (sof_i),
        .pending    (pending),
        .copy_en    (copy_en),
        .blink_mode (blink_mode),
        .flags      (flags),
        .ien        (ien),
        .irq        (irq_o)
    );

    lcdram_banks #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .we         (host_we && sel_ram),
        .waddr      (host_addr[IDX_W-1:0]),
        .wdata      (host_wdata),
        .copy_en    (copy_en),
        .host_raddr (host_addr[IDX_W-1:0]),
        .host_rword (host_rword),
        .disp_raddr (disp_addr_i),
        .disp_rword (disp_rword)
    );

    lcdram_blink #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_blink (
        .clk       (clk),
        .rst       (rst),
        .word_in   (disp_rword),
        .addr      (disp_addr_i),
        .mode      (blink_mode),
        .blink_off (blink_off_i),
        .data_o    (disp_data_o)
    );

    always_comb begin
        host_rdata = '0;
        if (sel_ram) begin
            host_rdata = host_rword;
        end else if (sel_ctrl) begin
            host_rdata[0]   = pending;
            host_rdata[6:4] = blink_mode;
        end else if (sel_stat) begin
            host_rdata[1:0] = flags;
        end else if (sel_ien) begin
            host_rdata[1:0] = ien;
        end
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flags != '0)); // R6

endmodule

// File: tb/lcd_pixel_ram_tb.sv
module lcd_pixel_ram_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sof_i = 1'b0;
    logic        blink_off_i = 1'b0;
    logic [3:0]  disp_addr_i = '0;
    logic [31:0] disp_data_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lcd_pixel_ram dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sof_i(sof_i),
        .blink_off_i(blink_off_i), .disp_addr_i(disp_addr_i),
        .disp_data_o(disp_data_o), .irq_o(irq_o)
    );

    localparam int NV = 6;
    localparam logic [3:0]  VA [NV] = '{4'd0, 4'd3, 4'd7, 4'd8, 4'd14, 4'd15};
    localparam logic [31:0] VD [NV] = '{32'hA5A5_0001, 32'h1234_5678, 32'hFFFF_0000,
                                        32'h0000_FFFF, 32'hDEAD_BEEF, 32'h8000_0001};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic dread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        disp_addr_i = a;
        @(negedge clk);
        d = disp_data_o;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        sof_i = 1'b1;
        @(negedge clk);
        sof_i = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(5'd0, v);  check("R1 word0", v, 32'h0);
        hread(5'd17, v); check("R1 status", v, 32'h0);
        hread(5'd16, v); check("R1 ctrl", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        dread(4'd0, v);  check("R1 display", v, 32'h0);

        // R2 vector walk: host readback immediate, display untouched
        for (int i = 0; i < NV; i++) begin
            hwrite({1'b0, VA[i]}, VD[i]);
            hread({1'b0, VA[i]}, v); check("R2 host readback", v, VD[i]);
            dread(VA[i], v);         check("R2 display unchanged", v, 32'h0);
        end

        // R3 request set; writing 0 does not clear
        hwrite(5'd16, 32'h1);
        hread(5'd16, v); check("R3 pending set", v, 32'h1);
        hwrite(5'd16, 32'h0);
        hread(5'd16, v); check("R3 pending held", v, 32'h1);

        // R4 write during pending goes to host bank only
        hwrite(5'd3, 32'hCAFE_F00D);
        dread(4'd3, v); check("R4 not shown before sof", v, 32'h0);

        frame_pulse();
        hread(5'd16, v); check("R3 pending cleared", v, 32'h0);
        hread(5'd17, v); check("R5 both flags", v, 32'h3);
        for (int i = 0; i < NV; i++) begin
            dread(VA[i], v);
            check("R3 copied word", v, (VA[i] == 4'd3) ? 32'hCAFE_F00D : VD[i]);
        end

        // R7 one-cycle latency
        @(negedge clk); disp_addr_i = 4'd7;
        @(negedge clk); disp_addr_i = 4'd8;
        #1 check("R7 old word before edge", disp_data_o, 32'hFFFF_0000);
        @(negedge clk); check("R7 new word after edge", disp_data_o, 32'h0000_FFFF);

        // R5 write-1-to-clear individual bit
        hwrite(5'd17, 32'h1);
        hread(5'd17, v); check("R5 clear sof only", v, 32'h2);
        hwrite(5'd17, 32'h2);
        hread(5'd17, v); check("R5 clear done", v, 32'h0);

        // R10 sof without request
        hwrite(5'd8, 32'h1111_1111);
        frame_pulse();
        dread(4'd8, v);  check("R10 no copy", v, 32'h0000_FFFF);
        hread(5'd17, v); check("R10 done not set", v, 32'h1);

        // R6 interrupt enables
        check("R6 irq masked", {31'b0, irq_o}, 32'h0);
        hwrite(5'd18, 32'h1);
        check("R6 irq sof enabled", {31'b0, irq_o}, 32'h1);
        hwrite(5'd18, 32'h2);
        check("R6 irq done only", {31'b0, irq_o}, 32'h0);
        hwrite(5'd18, 32'h0);

        // R8/R9 blink: all words ones
        for (int w = 0; w < 16; w++) hwrite(5'(w), 32'hFFFF_FFFF);
        hwrite(5'd16, 32'h11);          // request + group code 1
        frame_pulse();
        blink_off_i = 1'b1;
        dread(4'd0, v);  check("R8 code1 word0", v, 32'hFFFF_FFFE);
        dread(4'd2, v);  check("R8 code1 word2", v, 32'hFFFF_FFFF);
        hwrite(5'd16, 32'h40);          // code 4
        dread(4'd6, v);  check("R8 code4 word6", v, 32'hFFFF_FFFE);
        dread(4'd8, v);  check("R8 code4 word8", v, 32'hFFFF_FFFF);
        hwrite(5'd16, 32'h50);          // code 5
        dread(4'd14, v); check("R8 code5 word14", v, 32'hFFFF_FFFE);
        dread(4'd1, v);  check("R8 code5 odd word", v, 32'hFFFF_FFFF);
        hwrite(5'd16, 32'h60);          // code 6
        dread(4'd7, v);  check("R8 all word7", v, 32'h0);
        blink_off_i = 1'b0;
        dread(4'd7, v);  check("R9 restored", v, 32'hFFFF_FFFF);
        blink_off_i = 1'b1;
        hwrite(5'd16, 32'h00);          // code 0
        dread(4'd0, v);  check("R9 code0 no mask", v, 32'hFFFF_FFFF);
        blink_off_i = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule